// File: doc/BRIEF.md
# Pulse-Height Window Discriminator

This block watches a stream of unsigned samples that carry shaped positive pulses. It sorts each pulse by amplitude against a lower and an upper threshold. It also gives every pulse a timing mark at the point where the trailing edge falls to half of the held peak. When the mark arrives, the block judges the pulse from two flags that were latched on the leading edge. The judgement gives either a one-cycle accept strobe or nothing. The block also reports each rising crossing of either threshold as it happens.

The lower threshold comes from a configuration value or from an external reference input, chosen by a select bit. The upper threshold is set one of two ways. It can be an independent level. Or, in window mode, it is the lower threshold plus one tenth of the width input. The block re-arms internally once three events have all been seen, in any order: the lower crossing, the fall back below the lower threshold, and the timing mark. That internal reset is reported as a one-cycle pulse.

Top module: `phd_core`

## Requirements
- R1: After reset and with no valid samples, every output is 0, including `mark_idx`.
- R2: Each output reflects the valid sample accepted at the previous rising clock edge, and every event output is a one-cycle pulse.
- R3: `lo_cross` pulses when the previous valid sample is at or below the lower threshold and the current one is above it. `hi_cross` does the same for the upper threshold. Both behave this way in every mode.
- R4: With `lo_src_ext` = 1 the lower threshold is `thr_lo_ext` and `thr_lo_reg` has no effect. With `lo_src_ext` = 0 it is `thr_lo_reg` and `thr_lo_ext` has no effect. This holds in every mode.
- R5: Mode codes for `disc_mode`: 2'b00 integral, 2'b01 normal, 2'b10 window, 2'b11 same as normal. In window mode the upper threshold is the lower threshold plus floor(`thr_hi_or_width` / 10). In the other modes it is `thr_hi_or_width`.
- R6: The timing stage arms only on a valid sample above `noise_floor` whose preceding valid sample was at or below `noise_floor`. A sequence that never rises above the floor gives no `tmark`.
- R7: Once the stage is armed, `tmark` pulses for the first later sample s where 2*s is at or below the held peak. `mark_idx` then holds the zero-based count of valid samples since reset at that sample.
- R8: In normal and window modes, `accept` pulses together with `tmark` only if the lower flag is set and the upper flag is clear.
- R9: In integral mode, `accept` pulses with `tmark` whenever the lower flag is set, whatever the upper flag holds.
- R10: `rearm` pulses in the first cycle in which the lower crossing, a sample at or below the lower threshold and the timing mark have all occurred, in either order of the two falling events. It clears both flags.
- R11: An upper flag that is set without a lower crossing stays set until a later `rearm`. A later in-window pulse is therefore rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid, clock enable of all state |
| smp | input | DW | Unsigned input sample |
| thr_lo_reg | input | DW | Configured lower threshold |
| thr_lo_ext | input | DW | External lower threshold reference |
| lo_src_ext | input | 1 | 1 selects the external lower threshold |
| thr_hi_or_width | input | DW | Upper threshold, or window width in window mode |
| disc_mode | input | 2 | 00 integral, 01 normal, 10 window, 11 normal |
| noise_floor | input | DW | Arming floor of the timing stage |
| lo_cross | output | 1 | Rising crossing of the lower threshold |
| hi_cross | output | 1 | Rising crossing of the upper threshold |
| accept | output | 1 | Pulse accepted at its timing mark |
| tmark | output | 1 | Half-peak timing mark on the trailing edge |
| mark_idx | output | IW | Sample index of the last timing mark |
| rearm | output | 1 | Internal reset of flags and held peak |

## Verification
The timing mark, with its accept decision, and the internal reset can land on the same sample. This happens when the first sample at or below half-peak is also the first sample at or below the lower threshold. The bench provokes it with a pulse whose half-peak equals the lower threshold exactly, and expects `accept`, `tmark` and `rearm` on the same sample index. It also runs pulses where the fall below the lower threshold comes before the mark and pulses where it comes after. In each case `rearm` must sit on the later of the two events and never before it.

// File: rtl/phd_pkg.sv
package phd_pkg;

  typedef enum logic [1:0] {
    MODE_INTEG  = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_WINDOW = 2'b10,
    MODE_RSVD   = 2'b11
  } phd_mode_e;

  localparam int unsigned NUM_DISC = 2;
  localparam int unsigned DISC_LO  = 0;
  localparam int unsigned DISC_HI  = 1;

endpackage

// File: rtl/phd_thresh.sv
module phd_thresh
  import phd_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned WIN_DIV = 10
) (
  input  logic          lo_src_ext_i,
  input  logic [DW-1:0] thr_lo_reg_i,
  input  logic [DW-1:0] thr_lo_ext_i,
  input  logic [DW-1:0] thr_hi_i,
  input  phd_mode_e     mode_i,
  output logic [DW-1:0] lo_thr_o,
  output logic [DW:0]   hi_thr_o
);

  localparam logic [DW-1:0] DIV_C = DW'(WIN_DIV);

  logic [DW-1:0] width_scaled;

  always_comb begin
    lo_thr_o     = lo_src_ext_i ? thr_lo_ext_i : thr_lo_reg_i;
    width_scaled = thr_hi_i / DIV_C;
    if (mode_i == MODE_WINDOW) begin
      hi_thr_o = {1'b0, lo_thr_o} + {1'b0, width_scaled};
    end else begin
      hi_thr_o = {1'b0, thr_hi_i};
    end
  end

endmodule

// File: rtl/phd_level_disc.sv
module phd_level_disc #(
  parameter int unsigned TW = 13
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [TW-1:0] smp_i,
  input  logic [TW-1:0] prev_i,
  input  logic [TW-1:0] thr_i,
  input  logic          clr_i,
  output logic          cross_o,
  output logic          flag_now_o
);

  logic flag_q, flag_n;

  always_comb begin
    cross_o    = en_i && (prev_i <= thr_i) && (smp_i > thr_i);
    flag_now_o = flag_q | cross_o;
    flag_n     = flag_q;
    if (en_i) begin
      flag_n = cross_o | (flag_q & ~clr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
    end
  end

  // R3
  cross_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cross_o |=> flag_q);

  // R11
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/phd_cfd.sv
module phd_cfd #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] prev_i,
  input  logic [DW-1:0] floor_i,
  input  logic          clr_i,
  output logic          mark_o,
  output logic          done_now_o
);

  logic          armed_q, armed_n;
  logic          done_q,  done_n;
  logic [DW-1:0] peak_q,  peak_n;
  logic          arm;
  logic [DW:0]   smp_x2;

  always_comb begin
    smp_x2     = {smp_i, 1'b0};
    mark_o     = en_i && armed_q && (smp_x2 <= {1'b0, peak_q});
    arm        = en_i && !armed_q && (smp_i > floor_i) && (prev_i <= floor_i);
    done_now_o = done_q | mark_o;

    armed_n = armed_q;
    done_n  = done_q;
    peak_n  = peak_q;
    if (en_i) begin
      if (clr_i) begin
        armed_n = 1'b0;
        done_n  = 1'b0;
        peak_n  = '0;
      end else if (mark_o) begin
        armed_n = 1'b0;
        done_n  = 1'b1;
      end else if (arm) begin
        armed_n = 1'b1;
        done_n  = 1'b0;
        peak_n  = smp_i;
      end else if (armed_q && (smp_i > peak_q)) begin
        peak_n  = smp_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      peak_q  <= '0;
    end else begin
      armed_q <= armed_n;
      done_q  <= done_n;
      peak_q  <= peak_n;
    end
  end

  // R6
  arm_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(armed_q) |-> ($past(smp_i) > $past(floor_i)));

  // R7
  mark_disarms_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mark_o |=> !armed_q);

endmodule

// File: rtl/phd_core.sv
module phd_core
  import phd_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned IW      = 16,
  parameter int unsigned WIN_DIV = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] thr_lo_reg,
  input  logic [DW-1:0] thr_lo_ext,
  input  logic          lo_src_ext,
  input  logic [DW-1:0] thr_hi_or_width,
  input  logic [1:0]    disc_mode,
  input  logic [DW-1:0] noise_floor,
  output logic          lo_cross,
  output logic          hi_cross,
  output logic          accept,
  output logic          tmark,
  output logic [IW-1:0] mark_idx,
  output logic          rearm
);

  localparam int unsigned TW = DW + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  phd_mode_e     mode;
  logic [DW-1:0] lo_thr;
  logic [DW:0]   hi_thr;
  logic [DW-1:0] prev_q, prev_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          below_q, below_n;
  logic          below_now, clr;
  logic          mark, cf_done_now;
  logic          acc_c;
  logic [TW-1:0] thr_v [NUM_DISC];
  logic [NUM_DISC-1:0] cross_v, flag_v;

  logic          lo_cross_n, hi_cross_n, accept_n, tmark_n, rearm_n;
  logic [IW-1:0] mark_idx_n;

  assign mode = phd_mode_e'(disc_mode);

  phd_thresh #(.DW(DW), .WIN_DIV(WIN_DIV)) u_thresh (
    .lo_src_ext_i (lo_src_ext),
    .thr_lo_reg_i (thr_lo_reg),
    .thr_lo_ext_i (thr_lo_ext),
    .thr_hi_i     (thr_hi_or_width),
    .mode_i       (mode),
    .lo_thr_o     (lo_thr),
    .hi_thr_o     (hi_thr)
  );

  assign thr_v[DISC_LO] = {1'b0, lo_thr};
  assign thr_v[DISC_HI] = hi_thr;

  for (genvar gi = 0; gi < NUM_DISC; gi++) begin : g_disc
    phd_level_disc #(.TW(TW)) u_disc (
      .clk        (clk),
      .rst_ni     (rst_ni),
      .en_i       (smp_vld),
      .smp_i      ({1'b0, smp}),
      .prev_i     ({1'b0, prev_q}),
      .thr_i      (thr_v[gi]),
      .clr_i      (clr),
      .cross_o    (cross_v[gi]),
      .flag_now_o (flag_v[gi])
    );
  end

  phd_cfd #(.DW(DW)) u_cfd (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .en_i       (smp_vld),
    .smp_i      (smp),
    .prev_i     (prev_q),
    .floor_i    (noise_floor),
    .clr_i      (clr),
    .mark_o     (mark),
    .done_now_o (cf_done_now)
  );

  always_comb begin
    below_now = below_q | (flag_v[DISC_LO] && (smp <= lo_thr));
    clr       = smp_vld && flag_v[DISC_LO] && below_now && cf_done_now;
    acc_c     = mark && flag_v[DISC_LO] &&
                (!flag_v[DISC_HI] || (mode == MODE_INTEG));

    below_n = below_q;
    prev_n  = prev_q;
    idx_n   = idx_q;
    if (smp_vld) begin
      below_n = clr ? 1'b0 : below_now;
      prev_n  = smp;
      idx_n   = idx_q + 1'b1;
    end

    lo_cross_n = cross_v[DISC_LO];
    hi_cross_n = cross_v[DISC_HI];
    tmark_n    = mark;
    accept_n   = acc_c;
    rearm_n    = clr;
    mark_idx_n = mark ? idx_q : mark_idx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      below_q  <= 1'b0;
      prev_q   <= '0;
      idx_q    <= '0;
      lo_cross <= 1'b0;
      hi_cross <= 1'b0;
      tmark    <= 1'b0;
      accept   <= 1'b0;
      rearm    <= 1'b0;
      mark_idx <= '0;
    end else begin
      below_q  <= below_n;
      prev_q   <= prev_n;
      idx_q    <= idx_n;
      lo_cross <= lo_cross_n;
      hi_cross <= hi_cross_n;
      tmark    <= tmark_n;
      accept   <= accept_n;
      rearm    <= rearm_n;
      mark_idx <= mark_idx_n;
    end
  end

  // R8
  accept_at_mark_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |-> tmark);

  // R10
  rearm_needs_lower_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rearm |-> $past(flag_v[DISC_LO]));

  // R5
  window_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MODE_WINDOW) |-> (hi_thr >= {1'b0, lo_thr}));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(smp_vld) |-> !(lo_cross || hi_cross || tmark || rearm));

endmodule

// File: tb/phd_core_test.sv
module phd_core_test;

  localparam int DW = 12;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_vld;
  logic [DW-1:0] smp, thr_lo_reg, thr_lo_ext, thr_hi_or_width, noise_floor;
  logic          lo_src_ext;
  logic [1:0]    disc_mode;
  logic          lo_cross, hi_cross, accept, tmark, rearm;
  logic [IW-1:0] mark_idx;

  always #10 clk = ~clk;

  phd_core #(.DW(DW), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .thr_lo_reg(thr_lo_reg), .thr_lo_ext(thr_lo_ext), .lo_src_ext(lo_src_ext),
    .thr_hi_or_width(thr_hi_or_width), .disc_mode(disc_mode),
    .noise_floor(noise_floor), .lo_cross(lo_cross), .hi_cross(hi_cross),
    .accept(accept), .tmark(tmark), .mark_idx(mark_idx), .rearm(rearm)
  );

  int n_chk = 0, n_err = 0;
  int gidx = 0;
  int n_lo, n_hi, n_acc, n_mk, n_rearm;
  int acc_pos, mk_pos, rearm_pos;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_lo = 0; n_hi = 0; n_acc = 0; n_mk = 0; n_rearm = 0;
    acc_pos = -1; mk_pos = -1; rearm_pos = -1;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    smp = DW'(v); smp_vld = 1'b1;
    @(posedge clk); #1;
    if (lo_cross) n_lo++;
    if (hi_cross) n_hi++;
    if (accept) begin n_acc++; acc_pos = gidx; end
    if (tmark) begin n_mk++; mk_pos = gidx; end
    if (rearm) begin n_rearm++; rearm_pos = gidx; end
    gidx++;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk); smp_vld = 1'b0; smp = '0;
    @(posedge clk); #1;
    // R2: nothing pulses for an invalid slot
    chk({tag, " R2 idle"}, int'({lo_cross, hi_cross, accept, tmark, rearm}), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", int'({lo_cross, hi_cross, accept, tmark, rearm}), 0);
    chk("R1 reset mark_idx", int'(mark_idx), 0);
  endtask

  // mark, fall below lower and accept on one sample
  task automatic t_normal_in_window();
    int b;
    thr_lo_reg = 1000; thr_lo_ext = 3900; lo_src_ext = 1'b0;
    thr_hi_or_width = 3000; disc_mode = 2'b01; noise_floor = 50;
    clear_counts(); b = gidx;
    push(0); push(600); push(1200); push(2000); push(1800);
    push(1400); push(1000); push(900); push(500); push(0);
    chk("R3 lower cross count", n_lo, 1);
    chk("R3 upper cross count", n_hi, 0);
    chk("R4 ext ignored, R8 accept pos", acc_pos, b + 6);
    chk("R7 tmark pos", mk_pos, b + 6);
    chk("R7 tmark count", n_mk, 1);
    chk("R7 mark_idx", int'(mark_idx), b + 6);
    chk("R10 rearm coincident", rearm_pos, b + 6);
    idle_check("T1");
  endtask

  // mark before the fall below lower; upper crossed
  task automatic t_above_upper(input logic [1:0] m, input int exp_acc);
    int b;
    thr_lo_reg = 1000; thr_hi_or_width = 3000; disc_mode = m;
    clear_counts(); b = gidx;
    push(0); push(1500); push(3500); push(3200); push(1600); push(1000); push(0);
    chk("R3 upper cross", n_hi, 1);
    chk("R7 tmark pos", mk_pos, b + 4);
    if (exp_acc != 0) chk("R9 integral accept", acc_pos, b + 4);
    else chk("R8 upper reject (R5 mode 11 as normal)", n_acc, 0);
    chk("R10 rearm after fall", rearm_pos, b + 5);
  endtask

  task automatic t_window();
    int b;
    thr_lo_reg = 1000; thr_hi_or_width = 2000; disc_mode = 2'b10;
    clear_counts(); b = gidx;
    push(0); push(1100); push(1150); push(900); push(500); push(0);
    chk("R5 window inside accept", acc_pos, b + 4);
    chk("R10 rearm after mark", rearm_pos, b + 4);
    chk("R5 no upper cross", n_hi, 0);
    clear_counts(); b = gidx;
    push(0); push(1300); push(900); push(600); push(0);
    chk("R5 window upper cross", n_hi, 1);
    chk("R8 window reject", n_acc, 0);
    chk("R10 rearm on reject", rearm_pos, b + 3);
  endtask

  task automatic t_ext_lower();
    int b;
    thr_lo_reg = 1000; thr_lo_ext = 2500; lo_src_ext = 1'b1;
    thr_hi_or_width = 4000; disc_mode = 2'b00;
    clear_counts(); b = gidx;
    push(0); push(2000); push(1500); push(900); push(0);
    chk("R4 ext lower, no cross", n_lo, 0);
    chk("R7 noise pulse marked", mk_pos, b + 3);
    chk("R10 no rearm without lower", n_rearm, 0);
    chk("R9 no accept without lower", n_acc, 0);
    clear_counts(); b = gidx;
    push(0); push(3000); push(1400); push(0);
    chk("R4 ext lower cross", n_lo, 1);
    chk("R9 accept ext", acc_pos, b + 2);
    chk("R10 rearm ext", rearm_pos, b + 2);
    lo_src_ext = 1'b0;
  endtask

  task automatic t_floor_and_hold();
    int b;
    thr_lo_reg = 2000; thr_hi_or_width = 500; disc_mode = 2'b01; noise_floor = 50;
    clear_counts();
    push(0); push(40); push(50); push(30); push(0);
    chk("R6 below floor no tmark", n_mk, 0);
    clear_counts();
    push(0); push(1000); push(400); push(0);
    chk("R11 upper only cross", n_hi, 1);
    chk("R11 no rearm", n_rearm, 0);
    thr_hi_or_width = 4000;
    clear_counts(); b = gidx;
    push(0); push(2500); push(1000); push(0);
    chk("R11 held upper rejects", n_acc, 0);
    chk("R11 rearm clears", rearm_pos, b + 2);
    clear_counts(); b = gidx;
    push(0); push(2500); push(1000); push(0);
    chk("R11 accept after clear", acc_pos, b + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp = '0;
    thr_lo_reg = '0; thr_lo_ext = '0; lo_src_ext = 1'b0;
    thr_hi_or_width = '0; disc_mode = 2'b01; noise_floor = 50;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    t_reset();
    t_normal_in_window();
    t_above_upper(2'b01, 0);
    t_above_upper(2'b00, 1);
    t_above_upper(2'b11, 0);
    t_window();
    t_ext_lower();
    t_floor_and_hold();
    idle_check("end");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule